// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits on the receive side of an Ethernet MAC. It decides whether an incoming frame is kept or dropped by examining only the six destination address bytes that open the frame. The bytes arrive one per strobe. The first byte is marked by a start-of-frame flag. When the sixth byte has been taken, the block produces a single accept or reject decision together with a one-cycle valid strobe.

Four rules make the decision. A unicast destination must equal the programmed station address in all 48 bits. The broadcast address is always kept. A group (multicast) destination is hashed to a 6-bit index, and that index selects one bit of a 64-bit table. In promiscuous mode every frame is kept. The hash runs a reflected CRC-32 over the address. The CRC register is preloaded with all ones, each byte is fed least significant bit first, and the result is not inverted. The six lowest CRC bits, read in reverse order, form the table index. Filling the table and parsing any byte after the address are left to neighbouring logic.

Top module: `mc_hash_filter`

## Requirements
- R1: For a group destination (bit 0 of the first address byte set), the table index is formed in three steps. First, a reflected CRC-32 with polynomial 0xEDB88320 and an all-ones start value runs over the six bytes in arrival order, each byte least significant bit first, with no final inversion. Second, bits 5..0 of that CRC are taken. Third, those bits are reversed, so that CRC bit 0 becomes index bit 5. The frame is accepted exactly when the table bit at that index is set.
- R2: Table bits 63..32 come from `mc_table_hi` bits 31..0. Table bits 31..0 come from `mc_table_lo` bits 31..0.
- R3: A unicast destination (first-byte bit 0 clear) is accepted only when every byte matches the station address. Byte 0, the first on the wire, is compared with `sta_addr_lo[7:0]`, byte 3 with `sta_addr_lo[31:24]`, byte 4 with `sta_addr_hi[7:0]` and byte 5 with `sta_addr_hi[15:8]`. A difference in any single bit rejects the frame.
- R4: The hash table has no effect on unicast destinations. An all-ones table does not admit a unicast frame that differs from the station address.
- R5: The all-ones destination (broadcast) is accepted whatever the table contents.
- R6: When both table words are all ones, every group destination is accepted.
- R7: When `promisc_en` is high at the sixth byte, the frame is accepted whatever its address.
- R8: `decide_vld` is high for exactly one cycle, in the cycle after the sixth byte is taken. A byte is taken when `rx_byte_vld` is high and either `rx_sof` is high or the current frame has fewer than six bytes. Bytes after the sixth, and bytes seen before any `rx_sof`, produce no strobe and do not change a decision. A new frame may start in the cycle right after the sixth byte.
- R9: After reset, `decide_vld` and `decide_accept` are low. `decide_accept` is only ever high together with `decide_vld`.
- R10: Idle cycles (`rx_byte_vld` low) between address bytes do not change the decision or its strobe, apart from delaying the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_byte_vld | input | 1 | A destination byte is present on `rx_byte` |
| rx_sof | input | 1 | Marks the first byte of a frame; qualified by `rx_byte_vld` |
| rx_byte | input | 8 | Destination address byte |
| sta_addr_hi | input | 16 | Station address bytes 5 (bits 15:8) and 4 (bits 7:0) |
| sta_addr_lo | input | 32 | Station address bytes 3 (bits 31:24) down to 0 (bits 7:0) |
| mc_table_hi | input | 32 | Hash table bits 63..32 |
| mc_table_lo | input | 32 | Hash table bits 31..0 |
| promisc_en | input | 1 | Accept every frame |
| decide_vld | output | 1 | One-cycle strobe, the decision is valid |
| decide_accept | output | 1 | Keep the frame (only meaningful with `decide_vld`) |

## Verification
The bench sends four kinds of destination. Unicast addresses equal to the station address, or differing from it in a single bit of the first or last byte, show whether the byte ordering of the station registers is right. Group addresses are checked against a table holding only their own bit, and against a table holding every bit but theirs; addresses chosen to land in the upper and lower halves of the table separate a wrong index bit order from a wrong word split. Broadcast with an empty table, all-ones tables, and promiscuous mode check that the overrides take priority. Byte streams with gaps, trailing bytes, missing start flags and back-to-back frames test the byte counter and the strobe timing against a per-cycle reference model.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

   localparam int unsigned BYTE_W = 8;

   // Running per-frame address comparison state
   typedef struct packed {
      logic match;   // all bytes so far equal the station address
      logic bcast;   // all bytes so far are 0xFF
      logic group;   // group bit of the first byte
   } mhf_flags_t;

   localparam mhf_flags_t FLAGS_SEED = '{match: 1'b1, bcast: 1'b1, group: 1'b0};

endpackage

// File: rtl/mhf_crc_unit.sv
module mhf_crc_unit #(
   parameter int            CRC_W   = 32,
   parameter logic [31:0]   POLY    = 32'hEDB8_8320,
   parameter logic [31:0]   INIT    = 32'hFFFF_FFFF,
   parameter bit            REFLECT = 1'b1,
   parameter int            OUT_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             restart,
   input  logic [7:0]       data,
   output logic [OUT_W-1:0] crc_low_next
);

   localparam logic [CRC_W-1:0] POLY_W = POLY[CRC_W-1:0];
   localparam logic [CRC_W-1:0] INIT_W = INIT[CRC_W-1:0];

   if (CRC_W < OUT_W || CRC_W > 32) begin : g_bad_width
      $error("mhf_crc_unit: CRC_W must lie between OUT_W and 32");
   end

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] seed;
   logic [CRC_W-1:0] crc_next;

   assign seed = restart ? INIT_W : crc_q;

   if (REFLECT) begin : g_lsb_first
      always_comb begin
         crc_next = seed;
         for (int k = 0; k < 8; k++) begin
            if (crc_next[0] ^ data[k]) crc_next = (crc_next >> 1) ^ POLY_W;
            else                       crc_next = crc_next >> 1;
         end
      end
   end else begin : g_msb_first
      always_comb begin
         crc_next = seed;
         for (int k = 7; k >= 0; k--) begin
            if (crc_next[CRC_W-1] ^ data[k]) crc_next = (crc_next << 1) ^ POLY_W;
            else                             crc_next = crc_next << 1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    crc_q <= INIT_W;
      else if (step) crc_q <= crc_next;
   end

   assign crc_low_next = crc_next[OUT_W-1:0];

   // Cycles without a byte leave the running CRC untouched
   assert_crc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(crc_q));

endmodule

// File: rtl/mhf_addr_cmp.sv
module mhf_addr_cmp
   import mhf_pkg::*;
#(
   parameter  int ADDR_BYTES = 6,
   localparam int POS_W      = $clog2(ADDR_BYTES + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         step,
   input  logic                         restart,
   input  logic [POS_W-1:0]             pos,
   input  logic [BYTE_W-1:0]            data,
   input  logic [ADDR_BYTES*BYTE_W-1:0] station,
   output mhf_flags_t                   flags_next
);

   logic [BYTE_W-1:0] sta_b [ADDR_BYTES];

   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_sta_byte
      assign sta_b[g] = station[g*BYTE_W +: BYTE_W];
   end

   mhf_flags_t flags_q;
   mhf_flags_t seed;

   always_comb begin
      seed             = restart ? FLAGS_SEED : flags_q;
      flags_next.match = seed.match & (data == sta_b[pos]);
      flags_next.bcast = seed.bcast & (&data);
      flags_next.group = (pos == '0) ? data[0] : seed.group;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    flags_q <= '0;
      else if (step) flags_q <= flags_next;
   end

   // A mismatching byte can not be undone by later bytes of the same frame
   assert_match_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !restart && !flags_q.match) |=> !flags_q.match);

endmodule

// File: rtl/mhf_hash_lookup.sv
module mhf_hash_lookup #(
   parameter  int IDX_W       = 6,
   parameter  bit IDX_REVERSE = 1'b1,
   localparam int TABLE_W     = 1 << IDX_W,
   localparam int HALF_W      = TABLE_W / 2
) (
   input  logic [IDX_W-1:0]  crc_low,
   input  logic [HALF_W-1:0] table_hi,
   input  logic [HALF_W-1:0] table_lo,
   output logic              hit
);

   logic [IDX_W-1:0]   idx;
   logic [TABLE_W-1:0] tbl;

   if (IDX_REVERSE) begin : g_rev_idx
      for (genvar g = 0; g < IDX_W; g++) begin : g_bit
         assign idx[g] = crc_low[IDX_W-1-g];
      end
   end else begin : g_fwd_idx
      assign idx = crc_low;
   end

   assign tbl = {table_hi, table_lo};
   assign hit = tbl[idx];

endmodule

// File: rtl/mc_hash_filter.sv
module mc_hash_filter
   import mhf_pkg::*;
#(
   parameter  int          ADDR_BYTES  = 6,
   parameter  int          HASH_IDX_W  = 6,
   parameter  logic [31:0] CRC_POLY    = 32'hEDB8_8320,
   parameter  logic [31:0] CRC_INIT    = 32'hFFFF_FFFF,
   parameter  bit          CRC_REFLECT = 1'b1,
   parameter  bit          IDX_REVERSE = 1'b1,
   localparam int          STA_LO_W    = 32,
   localparam int          STA_HI_W    = ADDR_BYTES*BYTE_W - STA_LO_W,
   localparam int          TBL_HALF_W  = (1 << HASH_IDX_W) / 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rx_byte_vld,
   input  logic                  rx_sof,
   input  logic [BYTE_W-1:0]     rx_byte,
   input  logic [STA_HI_W-1:0]   sta_addr_hi,
   input  logic [STA_LO_W-1:0]   sta_addr_lo,
   input  logic [TBL_HALF_W-1:0] mc_table_hi,
   input  logic [TBL_HALF_W-1:0] mc_table_lo,
   input  logic                  promisc_en,
   output logic                  decide_vld,
   output logic                  decide_accept
);

   localparam int               CNT_W    = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] IDLE_POS = CNT_W'(ADDR_BYTES);
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

   if (ADDR_BYTES < 5 || ADDR_BYTES > 8) begin : g_bad_addr
      $error("mc_hash_filter: ADDR_BYTES must be 5 to 8");
   end
   if (HASH_IDX_W < 2 || HASH_IDX_W > 8) begin : g_bad_idx
      $error("mc_hash_filter: HASH_IDX_W must be 2 to 8");
   end

   // Byte position tracking
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] pos;
   logic             take;
   logic             last_byte;

   assign take      = rx_byte_vld && (rx_sof || (cnt_q != IDLE_POS));
   assign pos       = rx_sof ? '0 : cnt_q;
   assign last_byte = take && (pos == LAST_POS);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= IDLE_POS;
      else if (take) cnt_q <= pos + CNT_W'(1);
   end

   // Hash path
   logic [HASH_IDX_W-1:0] crc_low_nxt;
   logic                  tbl_hit;

   mhf_crc_unit #(
      .CRC_W   (32),
      .POLY    (CRC_POLY),
      .INIT    (CRC_INIT),
      .REFLECT (CRC_REFLECT),
      .OUT_W   (HASH_IDX_W)
   ) u_crc (
      .clk          (clk),
      .rst_n        (rst_n),
      .step         (take),
      .restart      (rx_sof),
      .data         (rx_byte),
      .crc_low_next (crc_low_nxt)
   );

   mhf_hash_lookup #(
      .IDX_W       (HASH_IDX_W),
      .IDX_REVERSE (IDX_REVERSE)
   ) u_lookup (
      .crc_low  (crc_low_nxt),
      .table_hi (mc_table_hi),
      .table_lo (mc_table_lo),
      .hit      (tbl_hit)
   );

   // Address comparison path
   mhf_flags_t flags_nxt;

   mhf_addr_cmp #(
      .ADDR_BYTES (ADDR_BYTES)
   ) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (take),
      .restart    (rx_sof),
      .pos        (pos),
      .data       (rx_byte),
      .station    ({sta_addr_hi, sta_addr_lo}),
      .flags_next (flags_nxt)
   );

   // Decision
   logic keep;

   always_comb begin
      if (promisc_en)           keep = 1'b1;
      else if (flags_nxt.bcast) keep = 1'b1;
      else if (flags_nxt.group) keep = tbl_hit;
      else                      keep = flags_nxt.match;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         decide_vld    <= 1'b0;
         decide_accept <= 1'b0;
      end else begin
         decide_vld    <= last_byte;
         decide_accept <= last_byte & keep;
      end
   end

   // Checks
   assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      decide_vld |-> $past(rx_byte_vld));

   assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      decide_vld |=> !decide_vld);

   assert_accept_qual_R9: assert property (@(posedge clk) disable iff (!rst_n)
      decide_accept |-> decide_vld);

   assert_promisc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (decide_vld && $past(promisc_en)) |-> decide_accept);

   assert_bcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (decide_vld && $past(flags_nxt.bcast)) |-> decide_accept);

   assert_all_mc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (decide_vld && $past(flags_nxt.group && (&{mc_table_hi, mc_table_lo})))
         |-> decide_accept);

   assert_unicast_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (decide_vld && $past(!flags_nxt.group && !flags_nxt.match && !promisc_en))
         |-> !decide_accept);

endmodule

// File: tb/tb_mc_hash_filter.sv
module tb_mc_hash_filter;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG_LIMIT = 20000;

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld   = 1'b0;
   logic        sof   = 1'b0;
   logic [7:0]  dat   = 8'h00;
   logic [15:0] sta_hi = 16'h0;
   logic [31:0] sta_lo = 32'h0;
   logic [31:0] tbl_hi = 32'h0;
   logic [31:0] tbl_lo = 32'h0;
   logic        prom  = 1'b0;
   logic        dec_v;
   logic        dec_a;

   always #(CLK_PERIOD/2) clk = ~clk;

   mc_hash_filter dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_byte_vld   (vld),
      .rx_sof        (sof),
      .rx_byte       (dat),
      .sta_addr_hi   (sta_hi),
      .sta_addr_lo   (sta_lo),
      .mc_table_hi   (tbl_hi),
      .mc_table_lo   (tbl_lo),
      .promisc_en    (prom),
      .decide_vld    (dec_v),
      .decide_accept (dec_a)
   );

   int    checks = 0;
   int    errors = 0;
   int    strobes = 0;
   bit    last_acc = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R9";

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Reference: hash index of a 48-bit destination (byte 0 in bits 7:0)
   function automatic int ref_index(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      int idx = 0;
      for (int i = 0; i < 6; i++) begin
         logic [7:0] b = a[8*i +: 8];
         for (int k = 0; k < 8; k++) begin
            if ((b[0] ^ c[0]) == 1'b1) c = (c >> 1) ^ 32'hEDB8_8320;
            else                       c = c >> 1;
            b = b >> 1;
         end
      end
      for (int k = 0; k < 6; k++) idx = (idx << 1) | int'(c[k]);
      return idx;
   endfunction

   function automatic bit ref_accept(input logic [47:0] a);
      logic [63:0] t = {tbl_hi, tbl_lo};
      if (prom) return 1'b1;
      if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
      if (a[0]) return t[ref_index(a)];
      return a == {sta_hi, sta_lo};
   endfunction

   // Cycle-level reference model
   int          m_cnt = 6;
   logic [47:0] m_addr = '0;
   bit          exp_v = 1'b0;
   bit          exp_a = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 6; exp_v = 1'b0; exp_a = 1'b0;
      end else begin
         exp_v = 1'b0; exp_a = 1'b0;
         if (vld && (sof || m_cnt < 6)) begin
            if (sof) m_cnt = 0;
            m_addr[8*m_cnt +: 8] = dat;
            m_cnt++;
            if (m_cnt == 6) begin
               exp_v = 1'b1;
               exp_a = ref_accept(m_addr);
            end
         end
      end
   end

   // Per-cycle comparison and strobe monitor, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check(cur_req, "cycle decide_vld", int'(dec_v), int'(exp_v));
         check(cur_req, "cycle decide_accept", int'(dec_a), int'(exp_a));
         if (dec_v) begin
            strobes++;
            last_acc = dec_a;
         end
      end
   end

   task automatic send(input logic [47:0] a, input int gap, input int extra, input bit with_sof);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         vld = 1'b1; sof = with_sof && (i == 0); dat = a[8*i +: 8];
         if (i < 5) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk); vld = 1'b0; sof = 1'b0;
            end
         end
      end
      for (int e = 0; e < extra; e++) begin
         @(negedge clk); vld = 1'b1; sof = 1'b0; dat = 8'hA5 ^ 8'(e);
      end
      @(negedge clk); vld = 1'b0; sof = 1'b0;
      @(negedge clk);
   endtask

   task automatic expect_frame(input logic [47:0] a, input bit exp, input string req,
                               input int gap, input int extra);
      int s0 = strobes;
      cur_req = req;
      send(a, gap, extra, 1'b1);
      check(req, "strobe count", strobes - s0, 1);
      check(req, "accept", int'(last_acc), int'(exp));
   endtask

   localparam logic [47:0] STA = 48'h6655_4433_2210;

   initial begin
      logic [47:0] mc_lo_a, mc_hi_a, a;
      int          idx_lo, idx_hi;
      logic [63:0] t;
      int          s0;

      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9", "reset decide_vld", int'(dec_v), 0);
      check("R9", "reset decide_accept", int'(dec_a), 0);
      rst_n = 1'b1;
      sta_hi = STA[47:32]; sta_lo = STA[31:0];
      @(negedge clk);
      check("R9", "idle decide_vld after reset", int'(dec_v), 0);

      // R8: bytes without a start flag are ignored
      cur_req = "R8";
      s0 = strobes;
      send(STA, 0, 0, 1'b0);
      check("R8", "no strobe without sof", strobes - s0, 0);

      // R3: exact match, and single-bit differences in first and last byte
      expect_frame(STA, 1'b1, "R3", 0, 0);
      expect_frame(STA ^ 48'h0000_0000_0002, 1'b0, "R3", 0, 0);
      expect_frame(STA ^ 48'h8000_0000_0000, 1'b0, "R3", 0, 0);
      expect_frame(STA ^ 48'h0001_0000_0000, 1'b0, "R3", 0, 0);

      // R4: table has no say on unicast
      tbl_hi = 32'hFFFF_FFFF; tbl_lo = 32'hFFFF_FFFF;
      expect_frame(48'h0102_0304_0500, 1'b0, "R4", 0, 0);
      expect_frame(STA, 1'b1, "R4", 0, 0);

      // R5: broadcast with an empty table
      tbl_hi = '0; tbl_lo = '0;
      expect_frame(48'hFFFF_FFFF_FFFF, 1'b1, "R5", 0, 0);

      // Find group addresses landing in each half of the table
      idx_lo = -1; idx_hi = -1; mc_lo_a = '0; mc_hi_a = '0;
      for (int k = 0; k < 256; k++) begin
         a = {8'(k), 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
         if (ref_index(a) < 32 && idx_lo < 0) begin idx_lo = ref_index(a); mc_lo_a = a; end
         if (ref_index(a) >= 32 && idx_hi < 0) begin idx_hi = ref_index(a); mc_hi_a = a; end
      end

      // R1: only the own bit set -> accept; all but own bit -> reject
      t = 64'd1 << idx_lo; tbl_hi = t[63:32]; tbl_lo = t[31:0];
      expect_frame(mc_lo_a, 1'b1, "R1", 0, 0);
      t = ~t; tbl_hi = t[63:32]; tbl_lo = t[31:0];
      expect_frame(mc_lo_a, 1'b0, "R1", 0, 0);

      // R2: word split of the table
      t = 64'd1 << idx_hi; tbl_hi = t[63:32]; tbl_lo = t[31:0];
      expect_frame(mc_hi_a, 1'b1, "R2", 0, 0);
      tbl_hi = '0; tbl_lo = 32'hFFFF_FFFF;
      expect_frame(mc_hi_a, 1'b0, "R2", 0, 0);
      expect_frame(mc_lo_a, 1'b1, "R2", 0, 0);

      // R6: all-ones table admits any group address
      tbl_hi = 32'hFFFF_FFFF; tbl_lo = 32'hFFFF_FFFF;
      expect_frame(mc_hi_a, 1'b1, "R6", 0, 0);
      expect_frame(48'h1234_5678_9ABB, 1'b1, "R6", 0, 0);

      // R7: promiscuous overrides everything
      tbl_hi = '0; tbl_lo = '0; prom = 1'b1;
      expect_frame(48'h0A0B_0C0D_0E0C, 1'b1, "R7", 0, 0);
      expect_frame(mc_lo_a, 1'b1, "R7", 0, 0);
      prom = 1'b0;
      expect_frame(48'h0A0B_0C0D_0E0C, 1'b0, "R7", 0, 0);

      // R10: gaps between bytes
      t = 64'd1 << idx_hi; tbl_hi = t[63:32]; tbl_lo = t[31:0];
      expect_frame(mc_hi_a, 1'b1, "R10", 2, 0);
      expect_frame(STA, 1'b1, "R10", 3, 0);

      // R8: trailing bytes give no second strobe and no change
      expect_frame(STA, 1'b1, "R8", 0, 4);
      expect_frame(mc_lo_a, 1'b0, "R8", 0, 3);

      // R8: back-to-back frames
      cur_req = "R8";
      s0 = strobes;
      for (int f = 0; f < 2; f++) begin
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            vld = 1'b1; sof = (i == 0); dat = (f == 0) ? STA[8*i +: 8] : mc_hi_a[8*i +: 8];
         end
      end
      @(negedge clk); vld = 1'b0; sof = 1'b0;
      @(negedge clk);
      check("R8", "back-to-back strobes", strobes - s0, 2);
      check("R8", "back-to-back second accept", int'(last_acc), 1);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WDOG_LIMIT) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule